// File: doc/BRIEF.md
# Banked Configuration Register Target

This block is the device side of a two-address configuration port. A host writes a register number to the index address. It then reads or writes that register through the data address. Register numbers below 0x30 form a global space that every device shares. From 0x30 upward the space is paged: a logical-device selector, held in global register 0x07, picks which device bank is visible there.

Each device bank contains:
- an enable byte at 0x30, which the host updates bit by bit with read-modify-write;
- a 16-bit primary I/O base at 0x60 (high) and 0x61 (low);
- a 16-bit secondary I/O base at 0x62 (high) and 0x63 (low);
- an interrupt byte at 0x70;
- a DMA byte at 0x74.

The global space holds a read-only chip identifier, high byte at 0x20 and low byte at 0x21, and a revision byte at 0x22. An external unlock detector drives a configuration-mode input, and data-port traffic counts only while that input is high. Banks exist for selector values 0 up to NUM_BANKS-1. The value 0xFF never maps to a bank, because the host parks its cached selector there.

Top module: `cfgport_target`

## Requirements
- R1: After reset the index register and the selector are 0x00, rdata_o is 0x00, and every per-device register in every bank reads 0x00.
- R2: A write with addr_i=0 latches wdata_i as the index, whether or not configuration mode is active. A read with addr_i=0 returns the index.
- R3: Global register 0x07 is the logical-device selector. In configuration mode a data write to it stores the full 8-bit value, and a data read returns that value.
- R4: Registers 0x20 and 0x21 read the high and low bytes of CHIP_ID, and 0x22 reads CHIP_REV. Data writes to these three registers change nothing.
- R5: Every other global register below 0x30 (all except 0x07, 0x20, 0x21 and 0x22) reads 0x00 and ignores writes.
- R6: When the selector holds a value below NUM_BANKS, registers 0x30, 0x60, 0x61, 0x62, 0x63, 0x70 and 0x74 are 8-bit read/write storage in the bank that value selects.
- R7: A data write changes only the bank named by the selector at the time of the write. The same registers in other banks keep their values.
- R8: When the selector is NUM_BANKS or above, including 0xFF, per-device reads return 0x00 and per-device writes change no bank.
- R9: While cfg_mode_i is low, data-port writes are ignored and data-port reads return 0xFF.
- R10: Read data is registered. The value for a read strobe appears on rdata_o after the clock edge that samples the strobe, and rdata_o holds that value until the next read strobe.
- R11: Offsets at 0x30 and above that are not among the seven bank registers read 0x00 and ignore writes.
- R12: Global registers below 0x30 return the same value whatever the selector holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode_i | input | 1 | Configuration mode active, from the unlock detector |
| addr_i | input | 1 | 0 = index address, 1 = data address |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
A write takes effect at the clock edge that samples its strobe, so the next access can already observe it. A read result is due one edge after the read strobe is sampled. The bench raises each strobe at a falling edge and drops it at the next falling edge. It samples rdata_o at that second falling edge, half a period after the capturing edge. Hold behaviour is checked by sampling rdata_o again after idle cycles and after writes, with no read in between.

// File: rtl/cfgport_pkg.sv
// Package: shared offsets, the bank slot map and the decode type for the
// banked configuration target. Assumes 8-bit register numbers.
package cfgport_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned SLOT_COUNT = 7;
    localparam int unsigned SLOT_W     = $clog2(SLOT_COUNT);

    localparam logic [BYTE_W-1:0] SEL_REG   = 8'h07;
    localparam logic [BYTE_W-1:0] IDH_REG   = 8'h20;
    localparam logic [BYTE_W-1:0] IDL_REG   = 8'h21;
    localparam logic [BYTE_W-1:0] REV_REG   = 8'h22;
    localparam logic [BYTE_W-1:0] PAGE_BASE = 8'h30;

    typedef logic [BYTE_W-1:0] cfg_byte_t;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] num;
    } slot_t;

    // Map a paged register number onto a storage slot inside a bank.
    function automatic slot_t map_slot(input cfg_byte_t idx);
        slot_t s;
        s.hit = 1'b1;
        s.num = '0;
        case (idx)
            8'h30:   s.num = SLOT_W'(0);
            8'h60:   s.num = SLOT_W'(1);
            8'h61:   s.num = SLOT_W'(2);
            8'h62:   s.num = SLOT_W'(3);
            8'h63:   s.num = SLOT_W'(4);
            8'h70:   s.num = SLOT_W'(5);
            8'h74:   s.num = SLOT_W'(6);
            default: s.hit = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cfgport_decode.sv
// Register decode: classifies the latched index as global or paged, finds
// the bank slot, and forms the global read value.
// Assumes the index and selector are stable registers.
module cfgport_decode
    import cfgport_pkg::*;
#(
    parameter logic [15:0] CHIP_ID  = 16'h5A17,
    parameter logic [7:0]  CHIP_REV = 8'h03
) (
    input  cfg_byte_t index_i,
    input  cfg_byte_t sel_i,
    output logic      is_sel_o,
    output logic      is_paged_o,
    output slot_t     slot_o,
    output cfg_byte_t glob_rd_o
);

    // Region and slot classification of the current index.
    always_comb begin
        is_sel_o   = (index_i == SEL_REG);
        is_paged_o = (index_i >= PAGE_BASE);
        slot_o     = map_slot(index_i);
    end

    // Read value for the global space; unlisted registers read zero.
    always_comb begin
        case (index_i)
            SEL_REG: glob_rd_o = sel_i;
            IDH_REG: glob_rd_o = CHIP_ID[15:8];
            IDL_REG: glob_rd_o = CHIP_ID[7:0];
            REV_REG: glob_rd_o = CHIP_REV;
            default: glob_rd_o = '0;
        endcase
    end

endmodule

// File: rtl/cfgport_bank.sv
// One logical-device bank: SLOT_COUNT byte registers, each written when
// its slot is addressed and the bank is selected.
// Assumes wr_en_i already folds in selection and mode gating.
module cfgport_bank
    import cfgport_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en_i,
    input  slot_t     slot_i,
    input  cfg_byte_t wdata_i,
    output cfg_byte_t rdata_o
);

    cfg_byte_t store_q [SLOT_COUNT];
    cfg_byte_t pick [SLOT_COUNT];

    for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
        // Storage byte for slot s, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                store_q[s] <= '0;
            else if (wr_en_i && slot_i.hit && (slot_i.num == SLOT_W'(s)))
                store_q[s] <= wdata_i;
        end
        // Masked contribution of slot s to the read value.
        assign pick[s] = (slot_i.hit && (slot_i.num == SLOT_W'(s))) ? store_q[s] : '0;
    end

    // OR-combine the one-hot slot contributions.
    always_comb begin
        rdata_o = '0;
        for (int s = 0; s < SLOT_COUNT; s++)
            rdata_o = rdata_o | pick[s];
    end

endmodule

// File: rtl/cfgport_target.sv
// Top: index/data configuration port with a global register space below
// 0x30 and selector-paged device banks above. Data-port traffic requires
// cfg_mode_i. NUM_BANKS must lie in 1..255 so 0xFF never names a bank.
module cfgport_target
    import cfgport_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter logic [15:0] CHIP_ID   = 16'h5A17,
    parameter logic [7:0]  CHIP_REV  = 8'h03
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_mode_i,
    input  logic       addr_i,
    input  logic       wr_i,
    input  logic       rd_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o
);

    localparam cfg_byte_t BANK_LIMIT = cfg_byte_t'(NUM_BANKS);

    cfg_byte_t index_q;
    cfg_byte_t ldn_q;
    cfg_byte_t rdata_q;

    logic      is_sel;
    logic      is_paged;
    slot_t     slot;
    cfg_byte_t glob_rd;
    cfg_byte_t page_rd;
    logic      data_wr;
    logic      idx_wr;
    logic      bank_live;

    logic      bank_hit [NUM_BANKS];
    cfg_byte_t bank_rd  [NUM_BANKS];

    // Strobe qualification for the two addresses.
    always_comb begin
        idx_wr    = wr_i && !addr_i;
        data_wr   = wr_i && addr_i && cfg_mode_i;
        bank_live = (ldn_q < BANK_LIMIT);
    end

    cfgport_decode #(
        .CHIP_ID  (CHIP_ID),
        .CHIP_REV (CHIP_REV)
    ) decode_i (
        .index_i    (index_q),
        .sel_i      (ldn_q),
        .is_sel_o   (is_sel),
        .is_paged_o (is_paged),
        .slot_o     (slot),
        .glob_rd_o  (glob_rd)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign bank_hit[g] = (ldn_q == cfg_byte_t'(g));
        cfgport_bank bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en_i (data_wr && is_paged && bank_hit[g]),
            .slot_i  (slot),
            .wdata_i (wdata_i),
            .rdata_o (bank_rd[g])
        );
    end

    // Select the read value of the bank named by the selector.
    always_comb begin
        page_rd = '0;
        for (int g = 0; g < NUM_BANKS; g++)
            if (bank_hit[g])
                page_rd = page_rd | bank_rd[g];
        if (!bank_live)
            page_rd = '0;
    end

    // Index register: latches every write to the index address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= '0;
        else if (idx_wr)
            index_q <= wdata_i;
    end

    // Logical-device selector: written through the data port at 0x07.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ldn_q <= '0;
        else if (data_wr && is_sel)
            ldn_q <= wdata_i;
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_i) begin
            if (!addr_i)
                rdata_q <= index_q;
            else if (!cfg_mode_i)
                rdata_q <= 8'hFF;
            else if (is_paged)
                rdata_q <= page_rd;
            else
                rdata_q <= glob_rd;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/cfgport_checker.sv
// Checker for cfgport_target, bound to every instance. Observes the port
// and the index/selector registers.
module cfgport_checker #(
    parameter int unsigned NUM_BANKS = 4,
    parameter logic [15:0] CHIP_ID   = 16'h5A17
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_mode_i,
    input logic       addr_i,
    input logic       wr_i,
    input logic       rd_i,
    input logic [7:0] wdata_i,
    input logic [7:0] rdata_o,
    input logic [7:0] index_q,
    input logic [7:0] ldn_q
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (index_q == 8'h00 && ldn_q == 8'h00 && rdata_o == 8'h00));

    assert_index_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !addr_i) |=> (index_q == $past(wdata_i)));

    assert_sel_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i && cfg_mode_i && index_q == 8'h07) |=> (ldn_q == $past(wdata_i)));

    assert_id_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i && cfg_mode_i && index_q == 8'h20) |=> (rdata_o == CHIP_ID[15:8]));

    assert_nobank_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i && cfg_mode_i && index_q >= 8'h30 && ldn_q >= 8'(NUM_BANKS))
        |=> (rdata_o == 8'h00));

    assert_locked_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i && !cfg_mode_i) |=> (rdata_o == 8'hFF));

    assert_locked_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i && !cfg_mode_i) |=> $stable(ldn_q));

    assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

endmodule

bind cfgport_target cfgport_checker #(
    .NUM_BANKS (NUM_BANKS),
    .CHIP_ID   (CHIP_ID)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mode_i (cfg_mode_i),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .index_q    (index_q),
    .ldn_q      (ldn_q)
);

// File: tb/cfgport_target_tb.sv
module cfgport_target_tb_top;

    localparam int unsigned NB  = 4;
    localparam logic [15:0] CID = 16'h5A17;
    localparam logic [7:0]  CRV = 8'h03;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b0;
    logic       addr = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] mdl [NB][7];
    logic [7:0] mdl_sel;

    always #10 clk = ~clk;

    cfgport_target #(.NUM_BANKS(NB), .CHIP_ID(CID), .CHIP_REV(CRV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode_i(cfg_mode), .addr_i(addr),
        .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata)
    );

    function automatic int slot_of(input logic [7:0] r);
        case (r)
            8'h30: return 0;
            8'h60: return 1;
            8'h61: return 2;
            8'h62: return 3;
            8'h63: return 4;
            8'h70: return 5;
            8'h74: return 6;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] exp_global(input logic [7:0] r, input logic [7:0] sel);
        if (r == 8'h07) return sel;
        if (r == 8'h20) return CID[15:8];
        if (r == 8'h21) return CID[7:0];
        if (r == 8'h22) return CRV;
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] r);
        int s;
        if (r < 8'h30) return exp_global(r, mdl_sel);
        s = slot_of(r);
        if (s < 0 || mdl_sel >= 8'(NB)) return 8'h00;
        return mdl[mdl_sel][s];
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic reg_wr(input logic [7:0] r, input logic [7:0] d);
        bus_wr(1'b0, r);
        bus_wr(1'b1, d);
        if (cfg_mode) begin
            if (r == 8'h07) mdl_sel = d;
            else if (r >= 8'h30 && slot_of(r) >= 0 && mdl_sel < 8'(NB))
                mdl[mdl_sel][slot_of(r)] = d;
        end
    endtask

    task automatic reg_rd(input logic [7:0] r, output logic [7:0] d);
        bus_wr(1'b0, r);
        bus_rd(1'b1, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] held;
        for (int b = 0; b < NB; b++)
            for (int s = 0; s < 7; s++) mdl[b][s] = 8'h00;
        mdl_sel = 8'h00;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", rdata, 8'h00);
        bus_rd(1'b0, v); check("R1 index", v, 8'h00);
        cfg_mode = 1'b1;
        reg_rd(8'h07, v); check("R1 selector", v, 8'h00);
        for (int b = 0; b < NB; b++) begin
            reg_wr(8'h07, 8'(b));
            for (int r = 8'h30; r < 8'h80; r++) begin
                if (slot_of(8'(r)) >= 0) begin
                    reg_rd(8'(r), v); check("R1 bank clear", v, 8'h00);
                end
            end
        end
        reg_wr(8'h07, 8'h00);

        // R2 index sweep, in and out of configuration mode
        for (int i = 0; i < 256; i++) begin
            cfg_mode = i[0];
            bus_wr(1'b0, 8'(i));
            bus_rd(1'b0, v); check("R2 index", v, 8'(i));
        end
        cfg_mode = 1'b1;

        // R3 selector values
        foreach (v[k]) begin end
        for (int k = 0; k < 5; k++) begin
            logic [7:0] s;
            s = (k == 0) ? 8'h03 : (k == 1) ? 8'h80 : (k == 2) ? 8'hFF : (k == 3) ? 8'h5A : 8'h00;
            reg_wr(8'h07, s);
            reg_rd(8'h07, v); check("R3 selector", v, s);
        end

        // R4 R5 R12 global sweep under several selector values
        for (int k = 0; k < 3; k++) begin
            reg_wr(8'h07, (k == 0) ? 8'h00 : (k == 1) ? 8'h02 : 8'hFF);
            for (int r = 0; r < 8'h30; r++) begin
                reg_rd(8'(r), v);
                check((r >= 8'h20 && r <= 8'h22) ? "R4 id/rev" : (r == 7) ? "R12 selector" : "R5 R12 global",
                      v, exp_global(8'(r), mdl_sel));
            end
        end
        for (int r = 0; r < 8'h30; r++)
            if (r != 7) begin
                bus_wr(1'b0, 8'(r)); bus_wr(1'b1, 8'hEE);
            end
        for (int r = 0; r < 8'h30; r++) begin
            reg_rd(8'(r), v);
            check((r >= 8'h20 && r <= 8'h22) ? "R4 write dropped" : "R5 write dropped",
                  v, exp_global(8'(r), mdl_sel));
        end

        // R6 R7 bank storage with a distinct pattern per bank and slot
        for (int b = 0; b < NB; b++) begin
            reg_wr(8'h07, 8'(b));
            for (int r = 8'h30; r < 8'h80; r++)
                if (slot_of(8'(r)) >= 0) reg_wr(8'(r), 8'(b * 37 + r * 3 + 5));
        end
        for (int b = NB - 1; b >= 0; b--) begin
            reg_wr(8'h07, 8'(b));
            for (int r = 8'h30; r < 8'h80; r++)
                if (slot_of(8'(r)) >= 0) begin
                    reg_rd(8'(r), v); check("R6 R7 bank data", v, exp_read(8'(r)));
                end
        end
        // R6 read-modify-write of the enable byte in bank 2
        reg_wr(8'h07, 8'h02);
        reg_rd(8'h30, v);
        reg_wr(8'h30, v | 8'h01);
        reg_rd(8'h30, v); check("R6 enable set", v, exp_read(8'h30));
        reg_wr(8'h30, v & 8'hFE);
        reg_rd(8'h30, v); check("R6 enable clear", v, exp_read(8'h30));

        // R11 unimplemented paged offsets in bank 1
        reg_wr(8'h07, 8'h01);
        for (int r = 8'h30; r < 256; r++)
            if (slot_of(8'(r)) < 0) reg_wr(8'(r), 8'hC3);
        for (int r = 8'h30; r < 256; r++) begin
            reg_rd(8'(r), v);
            check(slot_of(8'(r)) < 0 ? "R11 unimplemented" : "R11 neighbours kept", v, exp_read(8'(r)));
        end

        // R8 selector with no bank
        for (int k = 0; k < 2; k++) begin
            reg_wr(8'h07, (k == 0) ? 8'(NB) : 8'hFF);
            reg_wr(8'h60, 8'h99);
            reg_wr(8'h74, 8'h99);
            reg_rd(8'h60, v); check("R8 no bank read", v, 8'h00);
            reg_rd(8'h74, v); check("R8 no bank read", v, 8'h00);
        end
        for (int b = 0; b < NB; b++) begin
            reg_wr(8'h07, 8'(b));
            reg_rd(8'h60, v); check("R8 banks untouched", v, exp_read(8'h60));
            reg_rd(8'h74, v); check("R8 banks untouched", v, exp_read(8'h74));
        end

        // R9 configuration mode inactive
        reg_wr(8'h07, 8'h01);
        cfg_mode = 1'b0;
        reg_rd(8'h07, v); check("R9 locked read", v, 8'hFF);
        reg_rd(8'h60, v); check("R9 locked read", v, 8'hFF);
        reg_rd(8'h20, v); check("R9 locked read", v, 8'hFF);
        reg_wr(8'h07, 8'h03);
        reg_wr(8'h61, 8'h42);
        cfg_mode = 1'b1;
        reg_rd(8'h07, v); check("R9 selector kept", v, 8'h01);
        reg_rd(8'h61, v); check("R9 bank kept", v, exp_read(8'h61));

        // R10 read data holds without a read strobe
        reg_rd(8'h21, held); check("R10 read", held, CID[7:0]);
        repeat (3) @(negedge clk);
        check("R10 hold idle", rdata, held);
        reg_wr(8'h62, 8'h11);
        bus_wr(1'b0, 8'h22);
        check("R10 hold writes", rdata, held);
        bus_rd(1'b1, v); check("R10 next read", v, CRV);

        finish_run();
    end

endmodule